// File: doc/BRIEF.md
# Peripheral Chip Select Decoder

This block turns the address phase of a multiplexed address/data bus into seven active-low select lines for peripheral devices. A peripheral window of seven 256-byte regions, aligned on a 2 KB boundary, is placed by a programmable base and tagged as lying in either memory space or I/O space. When an address phase hits region n of that window in the matching space, select n goes low. It stays low until the next address phase is decoded.

The address is sampled on every rising clock edge at which the address strobe is high. The last such sample before the strobe falls is the one that stands for the bus cycle. The decode result is registered, so a select appears in the cycle right after the address is presented and stays steady for the whole bus cycle.

While the bus is handed to another master (hold acknowledged), every select is forced inactive and new address phases are ignored. An extend control picks what the pins for selects 5 and 6 carry. With extend set they are ordinary selects. With extend clear they carry latched address bits 1 and 2, and those bits keep their value while the bus is held. All control pins are plain levels with no handshake.

Top module: `pcs_decoder`

## Requirements
- R1: A rising edge with `rst_n` low clears all decode state. Afterwards `pcs_n` reads 7'h7F with `sel_ext`=1, and 7'h1F with `sel_ext`=0 (the latched address bits reset to 0).
- R2: Consider an edge where `ale`=1 and `hold_ack`=0, and the address meets all of these: `ad[19:11]` equals `base_hi`, `ad[10:8]` = n with n < 7, and `io_space` equals `base_io`. After that edge exactly `pcs_n[n]` is low and the other selects are high.
- R3: An address phase with `ad[10:8]` = 7 inside the window leaves every select high.
- R4: An address phase whose `ad[19:11]` differs from `base_hi` leaves every select high.
- R5: An address phase whose `io_space` differs from `base_io` leaves every select high.
- R6: While `ale` is low, the select outputs keep the value of the last decoded address phase, whatever `ad` and `io_space` do.
- R7: While `hold_ack` is high, every select pin is high in the same cycle. Address phases seen during hold are ignored. When hold is released, the select from before the hold returns.
- R8: With `sel_ext`=0, `pcs_n[5]` carries latched `ad[1]` and `pcs_n[6]` carries latched `ad[2]` from the last address phase taken. Pins 0 to 4 remain selects.
- R9: While `hold_ack` is high, the latched address bits on pins 5 and 6 keep their earlier value.
- R10: A change of `sel_ext` changes the function of pins 5 and 6 in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale | input | 1 | Address strobe; address sampled on edges where it is high |
| ad | input | 20 | Multiplexed bus, address during strobe |
| io_space | input | 1 | Cycle type: 1 = I/O, 0 = memory |
| hold_ack | input | 1 | Bus-hold acknowledge |
| base_hi | input | 9 | Window base, address bits 19..11 |
| base_io | input | 1 | Space of the window: 1 = I/O, 0 = memory |
| sel_ext | input | 1 | 1 = pins 5/6 are selects, 0 = latched A1/A2 |
| pcs_n | output | 7 | Active-low selects (pins 5/6 muxed) |

## Verification
Decode results (R2 to R6, R8) are due one rising edge after the strobe is driven. The bench drives every input on the falling edge and compares the pins a quarter period after the following falling edge, so the register has already updated. Hold forcing (R7) and extend switching (R10) are combinational. For these the pins are compared a quarter period after the input changes, with no clock edge in between. A bench model takes in an address phase only when it sees hold low at the sampling edge, as the requirements state.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int PCS_ADDR_W    = 20;
  localparam int PCS_REGION_LG = 8;
  localparam int PCS_NUM_SEL   = 7;
  localparam int PCS_EXT_PIN_A = 5;
  localparam int PCS_EXT_PIN_B = 6;

  typedef struct packed {
    logic a2;
    logic a1;
  } pcs_lat_bits_t;
endpackage

// File: rtl/pcs_region_decode.sv
module pcs_region_decode #(
  parameter int ADDR_W    = pcs_pkg::PCS_ADDR_W,
  parameter int REGION_LG = pcs_pkg::PCS_REGION_LG,
  parameter int NUM_SEL   = pcs_pkg::PCS_NUM_SEL,
  localparam int IDX_W    = $clog2(NUM_SEL + 1),
  localparam int BASE_LSB = REGION_LG + IDX_W,
  localparam int BASE_W   = ADDR_W - BASE_LSB
) (
  input  logic [ADDR_W-1:REGION_LG] ad_hi,
  input  logic                      io_space,
  input  logic [BASE_W-1:0]         base_hi,
  input  logic                      base_io,
  output logic [NUM_SEL-1:0]        hit_d
);
  logic             blk_match;
  logic [IDX_W-1:0] region;

  assign blk_match = (ad_hi[ADDR_W-1:BASE_LSB] == base_hi) && (io_space == base_io);
  assign region    = ad_hi[BASE_LSB-1:REGION_LG];

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lane
    assign hit_d[g] = blk_match && (region == IDX_W'(g));
  end
endmodule

// File: rtl/pcs_addr_capture.sv
module pcs_addr_capture #(
  parameter int NUM_SEL = pcs_pkg::PCS_NUM_SEL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ale,
  input  logic                  hold_ack,
  input  logic [NUM_SEL-1:0]    hit_d,
  input  logic [2:1]            ad_lo,
  output logic [NUM_SEL-1:0]    hit_q,
  output pcs_pkg::pcs_lat_bits_t lat_q
);
  logic take;
  assign take = ale && !hold_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= '0;
      lat_q <= '0;
    end else if (take) begin
      hit_q    <= hit_d;
      lat_q.a1 <= ad_lo[1];
      lat_q.a2 <= ad_lo[2];
    end
  end

  // R6: no address phase, decode state unchanged
  p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(hit_q));
  // R9: latched bits frozen during hold
  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |=> $stable(lat_q));
  // R7: phases during hold ignored
  p_hold_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |=> $stable(hit_q));
endmodule

// File: rtl/pcs_pin_mux.sv
module pcs_pin_mux #(
  parameter int NUM_SEL   = pcs_pkg::PCS_NUM_SEL,
  parameter int EXT_PIN_A = pcs_pkg::PCS_EXT_PIN_A,
  parameter int EXT_PIN_B = pcs_pkg::PCS_EXT_PIN_B
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SEL-1:0]     hit_q,
  input  pcs_pkg::pcs_lat_bits_t lat_q,
  input  logic                   hold_ack,
  input  logic                   sel_ext,
  output logic [NUM_SEL-1:0]     pcs_n
);
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_pin
    logic sel_n;
    assign sel_n = !(hit_q[g] && !hold_ack);
    if (g == EXT_PIN_A) begin : g_a1
      assign pcs_n[g] = sel_ext ? sel_n : lat_q.a1;
    end else if (g == EXT_PIN_B) begin : g_a2
      assign pcs_n[g] = sel_ext ? sel_n : lat_q.a2;
    end else begin : g_plain
      assign pcs_n[g] = sel_n;
    end
  end

  // R7: hold forces every select inactive
  p_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && sel_ext) |-> (pcs_n == '1));
  // R2: never more than one select low
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ext |-> $onehot0(~pcs_n));
endmodule

// File: rtl/pcs_decoder.sv
module pcs_decoder #(
  parameter int ADDR_W    = pcs_pkg::PCS_ADDR_W,
  parameter int REGION_LG = pcs_pkg::PCS_REGION_LG,
  parameter int NUM_SEL   = pcs_pkg::PCS_NUM_SEL,
  localparam int IDX_W    = $clog2(NUM_SEL + 1),
  localparam int BASE_W   = ADDR_W - REGION_LG - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ale,
  input  logic [ADDR_W-1:0]  ad,
  input  logic               io_space,
  input  logic               hold_ack,
  input  logic [BASE_W-1:0]  base_hi,
  input  logic               base_io,
  input  logic               sel_ext,
  output logic [NUM_SEL-1:0] pcs_n
);
  logic [NUM_SEL-1:0]     hit_d;
  logic [NUM_SEL-1:0]     hit_q;
  pcs_pkg::pcs_lat_bits_t lat_q;
  logic                   unused_addr_bits;

  assign unused_addr_bits = ^{ad[REGION_LG-1:3], ad[0]};

  pcs_region_decode #(.ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .NUM_SEL(NUM_SEL)) u_decode (
    .ad_hi    (ad[ADDR_W-1:REGION_LG]),
    .io_space (io_space),
    .base_hi  (base_hi),
    .base_io  (base_io),
    .hit_d    (hit_d)
  );

  pcs_addr_capture #(.NUM_SEL(NUM_SEL)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .hold_ack (hold_ack),
    .hit_d    (hit_d),
    .ad_lo    (ad[2:1]),
    .hit_q    (hit_q),
    .lat_q    (lat_q)
  );

  pcs_pin_mux #(.NUM_SEL(NUM_SEL)) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_q    (hit_q),
    .lat_q    (lat_q),
    .hold_ack (hold_ack),
    .sel_ext  (sel_ext),
    .pcs_n    (pcs_n)
  );
endmodule

// File: tb/pcs_decoder_tb.sv
module pcs_decoder_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, ale, io_space, hold_ack, base_io, sel_ext;
  logic [19:0] ad;
  logic [8:0]  base_hi;
  logic [6:0]  pcs_n;

  int   n_chk = 0;
  int   n_fail = 0;
  logic [6:0] m_hit;
  logic m_a1, m_a2;

  pcs_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad(ad), .io_space(io_space),
    .hold_ack(hold_ack), .base_hi(base_hi), .base_io(base_io),
    .sel_ext(sel_ext), .pcs_n(pcs_n)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [6:0] ref_hit(logic [19:0] a, logic io);
    if (a[19:11] == base_hi && io == base_io && a[10:8] != 3'd7)
      return 7'd1 << a[10:8];
    return 7'd0;
  endfunction

  function automatic logic [6:0] ref_pins();
    logic [6:0] p;
    for (int i = 0; i < 7; i++) p[i] = !(m_hit[i] && !hold_ack);
    if (!sel_ext) begin
      p[5] = m_a1;
      p[6] = m_a2;
    end
    return p;
  endfunction

  task automatic check(string req);
    logic [6:0] e;
    e = ref_pins();
    n_chk++;
    if (pcs_n !== e) begin
      n_fail++;
      $display("FAIL %s: pcs_n=%b expected=%b", req, pcs_n, e);
    end
  endtask

  task automatic phase(logic [19:0] a, logic io, string req);
    @(negedge clk);
    ale = 1'b1; ad = a; io_space = io;
    @(posedge clk);
    if (!hold_ack) begin
      m_hit = ref_hit(a, io);
      m_a1  = a[1];
      m_a2  = a[2];
    end
    @(negedge clk);
    ale = 1'b0; ad = 20'($urandom); io_space = 1'($urandom);
    #(CLK_P/4) check(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ad = {base_hi, 11'($urandom)}; io_space = base_io;
      #(CLK_P/4) check("R6");
    end
  endtask

  task automatic set_hold(logic v, string req);
    @(negedge clk);
    hold_ack = v;
    #(CLK_P/4) check(req);
  endtask

  function automatic logic [19:0] in_win(logic [2:0] r, logic [7:0] lo);
    return {base_hi, r, lo};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; ale = 1'b0; ad = '0; io_space = 1'b0; hold_ack = 1'b0;
    base_hi = 9'h0A5; base_io = 1'b0; sel_ext = 1'b1;
    m_hit = '0; m_a1 = 1'b0; m_a2 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1");
    sel_ext = 1'b0;
    #(CLK_P/4) check("R1");
    @(negedge clk);
    sel_ext = 1'b1; rst_n = 1'b1;

    for (int r = 0; r < 7; r++) phase(in_win(3'(r), 8'h10), 1'b0, "R2");
    phase(in_win(3'd7, 8'h00), 1'b0, "R3");
    phase({base_hi ^ 9'h001, 3'd2, 8'h00}, 1'b0, "R4");
    phase({base_hi ^ 9'h100, 3'd0, 8'h00}, 1'b0, "R4");
    phase(in_win(3'd3, 8'h00), 1'b1, "R5");

    base_io = 1'b1;
    phase(in_win(3'd6, 8'hFF), 1'b1, "R2");
    phase(in_win(3'd6, 8'hFF), 1'b0, "R5");
    base_io = 1'b0;

    phase(in_win(3'd2, 8'h00), 1'b0, "R6");
    idle(5);

    phase(in_win(3'd4, 8'h00), 1'b0, "R7");
    set_hold(1'b1, "R7");
    phase(in_win(3'd1, 8'h00), 1'b0, "R7");
    set_hold(1'b0, "R7");

    sel_ext = 1'b0;
    phase(in_win(3'd0, 8'h02), 1'b0, "R8");
    phase({20'h12345 & 20'hFFFF8} | 20'h4, 1'b1, "R8");
    phase(in_win(3'd3, 8'h06), 1'b0, "R8");
    set_hold(1'b1, "R9");
    phase(in_win(3'd1, 8'h00), 1'b0, "R9");
    idle(2);
    set_hold(1'b0, "R9");

    @(negedge clk);
    sel_ext = 1'b1;
    #(CLK_P/4) check("R10");
    @(negedge clk);
    sel_ext = 1'b0;
    #(CLK_P/4) check("R10");

    for (int k = 0; k < 400; k++) begin
      logic [19:0] a;
      a = ($urandom_range(0, 3) != 0) ? in_win(3'($urandom), 8'($urandom)) : 20'($urandom);
      @(negedge clk);
      hold_ack = ($urandom_range(0, 9) == 0);
      sel_ext  = 1'($urandom);
      phase(a, ($urandom_range(0, 4) == 0) ? ~base_io : base_io, "R2");
      if ($urandom_range(0, 3) == 0) idle(1);
    end

    finish_run();
  end
endmodule